// File: doc/BRIEF.md
# Serial Control Port with Sync Abort

This block is the slave side of a four-wire serial register port. A host selects it by pulling an active-low select line, clocks bits in on a serial clock, and either writes a control byte into a small register bank or reads one back. Because the select is active low and every output is released while it is high, several such ports can share one clock and data bus.

Each transfer begins with an instruction byte and continues with one data byte, both most significant bit first. Read data normally returns on the same bidirectional data pin. A mode bit in register 0 turns that pin into an input only, and read data then leaves on a separate output pin instead. A synchronisation input lets the host throw away a transfer that has gone out of step, without disturbing any register that was already programmed. All port inputs are brought into the block clock domain through two-stage synchronisers, so the serial clock must run well below the block clock.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every register reads zero, the data pin is bidirectional, and neither the data pin nor the output pin is driven.
- R2: A transfer whose instruction bit 7 is 0 writes: bits 6..0 of the instruction give the register address, and the next 8 bits, sampled on rising serial-clock edges MSB first, are stored in that register once the 16th rising edge arrives.
- R3: A transfer whose instruction bit 7 is 1 reads: from the falling edge after the 8th rising edge onward, one data bit per falling edge is presented MSB first.
- R4: Raising the select before the 16th rising edge discards the transfer: no register changes and the next transfer starts with a fresh instruction.
- R5: A high level on the sync input aborts the transfer in progress without changing any register; with the select still low, the next rising edge begins a new instruction.
- R6: When bit 7 of register 0 is 1 the data pin is never driven, and read data appears on the output pin.
- R7: When bit 7 of register 0 is 0 the output pin is never driven and read data appears on the data pin.
- R8: Addresses at or above the register count are not stored on write and read back as zero.
- R9: Both pins are released while the select is high.
- R10: Rising edges beyond the 16th within one select window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, samples all port inputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| sync_abort | input | 1 | Active-high transfer abort |
| sdio | inout | 1 | Serial data in; read data out in bidirectional mode |
| sdo | output | 1 | Read data out in input-only mode, otherwise released |
| cfg_q | output | NUM_REGS*DATA_W | All register contents, register 0 in the low byte |

## Verification
Writes and read-backs are swept over every register with several arithmetic patterns and over a wide range of values in one register, which separates address decoding faults from bit ordering faults. Transfers cut short by the select and by the sync input, and an over-long transfer, tell a premature or late commit apart from a correct one. Reads of an all-ones register in both pin modes, against pulled-down bus lines, show which pin is driven and that the other stays released.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int MODE_BIT = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sync_abort,
  inout  wire                        sdio,
  output wire                        sdo,
  output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int LAST  = 8 + DATA_W;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] LASTC = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] INSTC = CNT_W'(8);

  logic [2:0] sclk_sh;
  logic [1:0] cs_sh, din_sh, sync_sh;
  logic [CNT_W-1:0] cnt;
  logic [7:0] instr;
  logic [DATA_W-1:0] wdat, rsh;
  logic [DATA_W-1:0] mem [NUM_REGS];
  logic out_bit, rd_on;

  wire rise    = sclk_sh[1] & ~sclk_sh[2];
  wire fall    = ~sclk_sh[1] & sclk_sh[2];
  wire cs_q    = cs_sh[1];
  wire sync_q  = sync_sh[1];
  wire din     = din_sh[1];
  wire idle    = cs_q | sync_q;
  wire mode    = mem[0][MODE_BIT];
  wire [7:0] next_instr = {instr[6:0], din};
  wire [DATA_W-1:0] next_wdat = {wdat[DATA_W-2:0], din};
  wire nx_hit  = int'(next_instr[6:0]) < NUM_REGS;
  wire cur_hit = int'(instr[6:0]) < NUM_REGS;

  assign sdio = (rd_on && !mode) ? out_bit : 1'bz;
  assign sdo  = (rd_on &&  mode) ? out_bit : 1'bz;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_q[g*DATA_W +: DATA_W] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sh <= '0;
      cs_sh   <= 2'b11;
      din_sh  <= '0;
      sync_sh <= '0;
    end else begin
      sclk_sh <= {sclk_sh[1:0], sclk};
      cs_sh   <= {cs_sh[0], cs_n};
      din_sh  <= {din_sh[0], sdio};
      sync_sh <= {sync_sh[0], sync_abort};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      instr   <= '0;
      wdat    <= '0;
      rsh     <= '0;
      out_bit <= 1'b0;
      rd_on   <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (idle) begin
      cnt   <= '0;
      rd_on <= 1'b0;
    end else begin
      if (rise && cnt != LASTC) begin
        cnt <= cnt + 1'b1;
        if (cnt < INSTC) begin
          instr <= next_instr;
          if (cnt == INSTC - 1'b1)
            rsh <= nx_hit ? mem[next_instr[IDX_W-1:0]] : '0;
        end else begin
          wdat <= next_wdat;
          if (cnt == LASTC - 1'b1 && !instr[7] && cur_hit)
            mem[instr[IDX_W-1:0]] <= next_wdat;
        end
      end
      if (fall && instr[7] && cnt >= INSTC && cnt < LASTC) begin
        out_bit <= rsh[DATA_W-1];
        rsh     <= {rsh[DATA_W-2:0], 1'b0};
        rd_on   <= 1'b1;
      end
    end
  end
endmodule

module serial_cfg_port_chk #(
  parameter int W     = 64,
  parameter int CNT_W = 5,
  parameter int LAST  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_q,
  input logic             sync_q,
  input logic             rd_on,
  input logic [CNT_W-1:0] cnt,
  input logic [W-1:0]     cfg_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cfg_q == '0)); // R1
  AST_READ_AFTER_INSTR: assert property (@(posedge clk) disable iff (rst) rd_on |-> (int'(cnt) >= 8)); // R3
  AST_CS_HOLDS_CFG: assert property (@(posedge clk) disable iff (rst) cs_q |=> $stable(cfg_q)); // R4
  AST_SYNC_HOLDS_CFG: assert property (@(posedge clk) disable iff (rst) sync_q |=> $stable(cfg_q)); // R5
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst) cs_q |=> !rd_on); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) int'(cnt) <= LAST); // R10
endmodule

bind serial_cfg_port serial_cfg_port_chk #(
  .W(NUM_REGS*DATA_W), .CNT_W(CNT_W), .LAST(LAST)
) u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .sync_q(sync_q),
  .rd_on(rd_on), .cnt(cnt), .cfg_q(cfg_q)
);

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
  localparam int NR = 8;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sync_abort = 1'b0;
  logic tb_oe = 1'b0, tb_bit = 1'b0;
  wire sdio, sdo;
  logic [NR*8-1:0] cfg_q;
  logic [7:0] model [NR];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  pulldown (sdio);
  pulldown (sdo);
  assign sdio = tb_oe ? tb_bit : 1'bz;

  always #10 clk = ~clk;

  serial_cfg_port i_serial_cfg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sync_abort(sync_abort),
    .sdio(sdio), .sdo(sdo), .cfg_q(cfg_q)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // end_mode 0: raise select at the end; 1: pulse sync and keep select low
  task automatic xfer(input logic [7:0] ins, input logic [7:0] wd, input int nbits,
                      input int end_mode, output logic [7:0] rio, output logic [7:0] ro);
    rio = '0; ro = '0;
    cs_n = 1'b0;
    waitc(HP);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) begin tb_oe = 1'b1; tb_bit = ins[7-i]; end
      else if (!ins[7] && i < 16) begin tb_oe = 1'b1; tb_bit = wd[15-i]; end
      else tb_oe = 1'b0;
      waitc(HP);
      if (i >= 8 && i < 16) begin rio[15-i] = sdio; ro[15-i] = sdo; end
      sclk = 1'b1;
      waitc(HP);
      sclk = 1'b0;
    end
    tb_oe = 1'b0;
    waitc(HP);
    if (end_mode == 1) begin
      sync_abort = 1'b1; waitc(HP); sync_abort = 1'b0; waitc(HP);
    end else begin
      cs_n = 1'b1; waitc(HP + 4);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] x, y;
    xfer({1'b0, 7'(a)}, d, 16, 0, x, y);
    if (a < NR) model[a] = d;
  endtask

  task automatic check_cfg(input string req);
    for (int k = 0; k < NR; k++)
      check(cfg_q[k*8 +: 8] == model[k], req, int'(cfg_q[k*8 +: 8]), int'(model[k]));
  endtask

  initial begin
    logic [7:0] rio, ro;
    for (int k = 0; k < NR; k++) model[k] = '0;
    waitc(5); rst = 1'b0; waitc(5);

    // R1: reset state, released pins
    check(cfg_q == '0, "R1 cfg", int'(cfg_q[31:0]), 0);
    check(sdio == 1'b0 && sdo == 1'b0, "R1 pins", {sdio, sdo}, 0);
    for (int a = 0; a < NR; a++) begin
      xfer({1'b1, 7'(a)}, 8'h00, 16, 0, rio, ro);
      check(rio == 8'h00, "R1 read", rio, 0);
    end

    // R2, R3, R7: every register with several arithmetic patterns
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < NR; a++) wr(a, 8'((a * 37 + p * 91 + 5) ^ (p << 5)) & (a == 0 ? 8'h7F : 8'hFF));
      check_cfg("R2 write");
      for (int a = 0; a < NR; a++) begin
        xfer({1'b1, 7'(a)}, 8'h00, 16, 0, rio, ro);
        check(rio == model[a], "R3 read", rio, model[a]);
        check(ro == 8'h00, "R7 sdo idle", ro, 0);
      end
    end

    // R2/R3: value sweep on one register
    for (int v = 0; v < 256; v += 3) begin
      wr(5, 8'(v));
      check(cfg_q[5*8 +: 8] == 8'(v), "R2 sweep", int'(cfg_q[5*8 +: 8]), v);
      xfer({1'b1, 7'd5}, 8'h00, 16, 0, rio, ro);
      check(rio == 8'(v), "R3 sweep", rio, v);
    end

    // R4: select raised mid-transfer
    wr(2, 8'h3C);
    xfer({1'b0, 7'd2}, 8'hC3, 12, 0, rio, ro);
    check_cfg("R4 partial");
    xfer({1'b0, 7'd2}, 8'hC3, 15, 0, rio, ro);
    check_cfg("R4 15 bits");
    wr(2, 8'h5A);
    check_cfg("R4 recover");

    // R5: sync abort with select held low, then a fresh instruction
    wr(4, 8'h11);
    xfer({1'b0, 7'd4}, 8'hEE, 12, 1, rio, ro);
    check_cfg("R5 abort");
    xfer({1'b0, 7'd4}, 8'h77, 16, 0, rio, ro);
    model[4] = 8'h77;
    check_cfg("R5 resume");

    // R8: out-of-range address
    wr(9, 8'hAB);
    wr(100, 8'hCD);
    check_cfg("R8 write");
    xfer({1'b1, 7'd9}, 8'h00, 16, 0, rio, ro);
    check(rio == 8'h00, "R8 read", rio, 0);

    // R10: extra clocks after the 16th
    xfer({1'b0, 7'd3}, 8'h96, 24, 0, rio, ro);
    model[3] = 8'h96;
    check_cfg("R10 long");

    // R7/R9: all-ones read in bidirectional mode
    wr(1, 8'hFF);
    xfer({1'b1, 7'd1}, 8'h00, 16, 0, rio, ro);
    check(rio == 8'hFF, "R7 sdio data", rio, 8'hFF);
    check(ro == 8'h00, "R7 sdo released", ro, 0);
    check(sdio == 1'b0 && sdo == 1'b0, "R9 released", {sdio, sdo}, 0);

    // R6: input-only mode
    wr(0, 8'h80);
    check(cfg_q[7] == 1'b1, "R6 mode bit", cfg_q[7], 1);
    xfer({1'b1, 7'd1}, 8'h00, 16, 0, rio, ro);
    check(ro == 8'hFF, "R6 sdo data", ro, 8'hFF);
    check(rio == 8'h00, "R6 sdio released", rio, 0);
    xfer({1'b1, 7'd4}, 8'h00, 16, 0, rio, ro);
    check(ro == 8'h77, "R6 sdo pattern", ro, 8'h77);
    check(sdio == 1'b0 && sdo == 1'b0, "R9 released io-only", {sdio, sdo}, 0);
    wr(0, 8'h00);
    xfer({1'b1, 7'd1}, 8'h00, 16, 0, rio, ro);
    check(rio == 8'hFF && ro == 8'h00, "R7 back to bidir", {rio, ro}, 16'hFF00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule